// File: doc/BRIEF.md
# Misaligned Load/Store Access Splitter

This block sits between a load/store pipeline and the memory bus. It accepts one memory request at a time. A request carries a byte address, an operand size, a store flag, a floating-point-double flag, a noncacheable flag and right-justified store data. The block cuts the request into bus pieces, sends the pieces in ascending address order, and gathers the load bytes into a right-justified big-endian result. When the last piece is accepted, it returns that result.

Each piece normally covers the bytes of one 32-bit word and carries a word-aligned address and a byte-enable mask. An 8-byte floating-point operand on an 8-byte boundary is the exception: it goes out as a single wide piece. A tenure marker on each piece tells the bus where a new external transfer starts. A noncacheable request starts a new transfer at every double-word it enters. When the pieces walk onto a new 4 KB page, a permission input for that page is consulted before the first piece there is sent. If the page is refused, the request ends with a fault report, and the pieces that already went to the earlier page stay done.

Top module: `acc_split`

## Requirements
- R1: `req_ready` is 1 exactly when no request is outstanding. A request is taken when `req_valid` and `req_ready` are both 1, and `req_ready` stays 0 until the cycle its response or fault pulse is shown.
- R2: A request's first piece appears on the bus in the same cycle the request is offered, with `bus_tnew`=1. A request that crosses no word boundary makes exactly one piece.
- R3: A request whose bytes span more than one 32-bit word is split into one piece per word. Pieces go out in ascending address order, each on a word-aligned `bus_addr`. `bus_be` bit i enables the byte at word offset i, and the pieces together enable exactly the request's bytes.
- R4: An 8-byte request (`req_size`=3) with `req_fpdbl`=1 and an address that is a multiple of 8 is sent as one piece. That piece has `bus_wide`=1, `bus_be`=4'hF and an 8-byte-aligned address, and it uses all eight data lanes.
- R5: `bus_tnew` is 1 on the first piece of every request. It is also 1 on a later piece of a noncacheable request whose address has bit 2 clear, which means a double-word boundary was crossed. In every other case it is 0.
- R6: Store lanes: byte b of the operand is `req_wdata[8*(N-1-b)+:8]`, where N is the size in bytes and byte 0 sits at the lowest address. It is driven on lane j, which is `bus_wdata[8*j+:8]`, where j is the byte's offset from `bus_addr`.
- R7: Loads: lane j of `bus_rdata` carries the byte at `bus_addr`+j. `rsp_data` holds the operand right-justified in big-endian order with the upper bits zero. `rsp_valid` pulses for one cycle, one cycle after the last piece's handshake.
- R8: The first piece on a new 4 KB page is sent only while `pg_ok` is 1. Otherwise `bus_valid` stays 0 for it, and one cycle later `flt_valid` pulses. `flt_addr` then holds the page's first byte address and `flt_done` holds the number of pieces already completed. No `rsp_valid` follows.
- R9: Pieces completed before a fault are not repeated. The block is ready for a new request in the cycle its fault is reported.
- R10: While `bus_ready` is 0, a shown piece stays valid with unchanged address and byte enables.
- R11: Size codes 0, 1, 2 and 3 in `req_size` mean 1, 2, 4 and 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | AW | Byte address of the operand |
| req_size | input | 2 | Size code (1/2/4/8 bytes) |
| req_store | input | 1 | 1 = store, 0 = load |
| req_fpdbl | input | 1 | Floating-point double operand |
| req_nocache | input | 1 | Noncacheable request |
| req_wdata | input | 64 | Right-justified store operand |
| bus_valid | output | 1 | Piece presented |
| bus_ready | input | 1 | Bus takes the piece |
| bus_addr | output | AW | Word (or double-word) aligned piece address |
| bus_be | output | 4 | Byte enables per word offset |
| bus_wide | output | 1 | 8-byte single piece |
| bus_tnew | output | 1 | Piece opens a new bus transfer |
| bus_store | output | 1 | Piece is a write |
| bus_wdata | output | 64 | Store lanes |
| bus_rdata | input | 64 | Load lanes |
| pg_ok | input | 1 | Permission for the page of `bus_addr` |
| rsp_valid | output | 1 | Request finished |
| rsp_data | output | 64 | Assembled load operand |
| flt_valid | output | 1 | Data storage fault pulse |
| flt_addr | output | AW | First byte of the refused page |
| flt_done | output | 2 | Pieces completed before the fault |

## Verification
The first piece is due combinationally in the cycle the request is offered. Each later piece is due in the cycle after the previous handshake, or it holds during stalls. The response or fault pulse is due exactly one cycle after the last handshake or the refused piece. The bench drives inputs on the falling edge and samples one nanosecond later, so every handshake it records is the one the next rising edge will take. It measures the response latency as the gap between the last recorded handshake cycle and the pulse cycle, and requires that gap to be one.

// File: rtl/acc_split_pkg.sv
package acc_split_pkg;

  // size code -> byte count
  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // big-endian operand byte index -> byte slot in a right-justified operand
  function automatic logic [2:0] be_slot(input logic [1:0] code, input logic [2:0] b);
    logic [3:0] t;
    t = size_bytes(code) - 4'd1 - {1'b0, b};
    return t[2:0];
  endfunction

endpackage

// File: rtl/acc_piece.sv
module acc_piece
  import acc_split_pkg::*;
#(
  parameter int AW  = 32,
  parameter int PGB = 12
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          fp,
  input  logic          nc,
  input  logic [1:0]    idx,
  output logic [AW-1:0] p_addr,
  output logic [3:0]    p_be,
  output logic          p_wide,
  output logic          p_last,
  output logic          p_tnew,
  output logic          p_newpg
);
  localparam int WW = AW - 2;

  logic [AW-1:0] end_a;
  logic [WW-1:0] pw;
  logic [1:0]    span;
  logic [1:0]    lo, hi;

  always_comb begin
    end_a  = addr + AW'(size_bytes(size)) - AW'(1);
    span   = 2'(end_a[AW-1:2] - addr[AW-1:2]);
    pw     = addr[AW-1:2] + WW'(idx);
    p_wide = fp && (size == 2'd3) && (addr[2:0] == 3'b000);
    p_last = p_wide || (idx == span);
    p_addr = p_wide ? {addr[AW-1:3], 3'b000} : {pw, 2'b00};
    lo     = (idx == 2'd0) ? addr[1:0] : 2'd0;
    hi     = (idx == span) ? end_a[1:0] : 2'd3;
    for (int i = 0; i < 4; i++) begin
      p_be[i] = p_wide || ((2'(i) >= lo) && (2'(i) <= hi));
    end
    p_tnew  = (idx == 2'd0) || (nc && !p_wide && !pw[0]);
    p_newpg = (idx != 2'd0) && (p_addr[PGB-1:2] == '0);
  end
endmodule

// File: rtl/acc_lanes.sv
module acc_lanes
  import acc_split_pkg::*;
(
  input  logic [2:0]  req_lo,
  input  logic [1:0]  size,
  input  logic [2:0]  p_off,
  input  logic [3:0]  p_be,
  input  logic        p_wide,
  input  logic [63:0] wdata,
  input  logic [63:0] rdata,
  input  logic [63:0] acc_in,
  output logic [63:0] wdata_o,
  output logic [63:0] acc_o
);
  logic [7:0] en8;
  logic [2:0] b, pos;

  always_comb begin
    en8     = p_wide ? 8'hFF : {4'b0000, p_be};
    wdata_o = '0;
    acc_o   = acc_in;
    b       = '0;
    pos     = '0;
    for (int j = 0; j < 8; j++) begin
      b   = 3'(p_off + 3'(j) - req_lo);
      pos = be_slot(size, b);
      if (en8[j]) begin
        wdata_o[{3'(j), 3'b000} +: 8] = wdata[{pos, 3'b000} +: 8];
        acc_o[{pos, 3'b000} +: 8]     = rdata[{3'(j), 3'b000} +: 8];
      end
    end
  end
endmodule

// File: rtl/acc_split.sv
module acc_split #(
  parameter int AW  = 32,
  parameter int PGB = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_store,
  input  logic          req_fpdbl,
  input  logic          req_nocache,
  input  logic [63:0]   req_wdata,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_addr,
  output logic [3:0]    bus_be,
  output logic          bus_wide,
  output logic          bus_tnew,
  output logic          bus_store,
  output logic [63:0]   bus_wdata,
  input  logic [63:0]   bus_rdata,
  input  logic          pg_ok,
  output logic          rsp_valid,
  output logic [63:0]   rsp_data,
  output logic          flt_valid,
  output logic [AW-1:0] flt_addr,
  output logic [1:0]    flt_done
);
  logic          busy;
  logic [AW-1:0] r_addr;
  logic [1:0]    r_size, r_idx;
  logic          r_st, r_fp, r_nc;
  logic [63:0]   r_wdata, acc;

  // current request view: latched when busy, live port when idle
  logic [AW-1:0] c_addr;
  logic [1:0]    c_size, c_idx;
  logic          c_st, c_fp, c_nc;
  logic [63:0]   c_wdata, acc_base, merged;

  // named events for the checker
  logic take, active, fault_now, handshake, p_last, p_newpg;

  assign c_addr   = busy ? r_addr  : req_addr;
  assign c_size   = busy ? r_size  : req_size;
  assign c_st     = busy ? r_st    : req_store;
  assign c_fp     = busy ? r_fp    : req_fpdbl;
  assign c_nc     = busy ? r_nc    : req_nocache;
  assign c_wdata  = busy ? r_wdata : req_wdata;
  assign c_idx    = busy ? r_idx   : 2'd0;
  assign acc_base = busy ? acc     : '0;

  acc_piece #(.AW(AW), .PGB(PGB)) u_piece (
    .addr(c_addr), .size(c_size), .fp(c_fp), .nc(c_nc), .idx(c_idx),
    .p_addr(bus_addr), .p_be(bus_be), .p_wide(bus_wide), .p_last(p_last),
    .p_tnew(bus_tnew), .p_newpg(p_newpg)
  );

  acc_lanes u_lanes (
    .req_lo(c_addr[2:0]), .size(c_size), .p_off(bus_addr[2:0]), .p_be(bus_be),
    .p_wide(bus_wide), .wdata(c_wdata), .rdata(bus_rdata), .acc_in(acc_base),
    .wdata_o(bus_wdata), .acc_o(merged)
  );

  assign req_ready = !busy;
  assign take      = req_valid && !busy;
  assign active    = busy || req_valid;
  assign fault_now = active && p_newpg && !pg_ok;
  assign bus_valid = active && !fault_now;
  assign bus_store = c_st;
  assign handshake = bus_valid && bus_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; r_addr <= '0; r_size <= '0; r_idx <= '0;
      r_st <= 1'b0; r_fp <= 1'b0; r_nc <= 1'b0; r_wdata <= '0; acc <= '0;
      rsp_valid <= 1'b0; rsp_data <= '0;
      flt_valid <= 1'b0; flt_addr <= '0; flt_done <= '0;
    end else begin
      rsp_valid <= 1'b0;
      flt_valid <= 1'b0;
      if (take) begin
        r_addr <= req_addr; r_size <= req_size; r_st <= req_store;
        r_fp <= req_fpdbl; r_nc <= req_nocache; r_wdata <= req_wdata;
      end
      if (handshake) begin
        acc <= merged;
        if (p_last) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_data  <= c_st ? 64'd0 : merged;
        end else begin
          busy  <= 1'b1;
          r_idx <= c_idx + 2'd1;
        end
      end else if (fault_now) begin
        busy      <= 1'b0;
        flt_valid <= 1'b1;
        flt_addr  <= bus_addr;
        flt_done  <= c_idx;
      end else if (take) begin
        busy  <= 1'b1;
        r_idx <= 2'd0;
        acc   <= '0;
      end
    end
  end
endmodule

// File: rtl/acc_split_chk.sv
module acc_split_chk #(
  parameter int AW  = 32,
  parameter int PGB = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic [3:0]    bus_be,
  input logic          bus_wide,
  input logic          bus_tnew,
  input logic          rsp_valid,
  input logic          flt_valid,
  input logic [AW-1:0] flt_addr,
  input logic          handshake,
  input logic          p_last
);
  p_ready_after_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || flt_valid) |-> req_ready);

  p_first_piece_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (bus_valid && bus_tnew));

  p_word_piece_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_wide) |-> (bus_be != 4'b0000 && bus_addr[1:0] == 2'b00));

  p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && !p_last) |=> (bus_addr > $past(bus_addr)));

  p_wide_piece_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_wide) |-> (bus_be == 4'hF && bus_addr[2:0] == 3'b000));

  p_fault_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> (flt_addr[PGB-1:0] == '0 && !rsp_valid));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_be)));
endmodule

bind acc_split acc_split_chk #(.AW(AW), .PGB(PGB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
  .bus_be(bus_be), .bus_wide(bus_wide), .bus_tnew(bus_tnew),
  .rsp_valid(rsp_valid), .flt_valid(flt_valid), .flt_addr(flt_addr),
  .handshake(handshake), .p_last(p_last)
);

// File: tb/acc_split_bench.sv
module acc_split_bench;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, req_valid, req_ready, req_store, req_fpdbl, req_nocache;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic [63:0]   req_wdata;
  logic          bus_valid, bus_ready, bus_wide, bus_tnew, bus_store, pg_ok;
  logic [AW-1:0] bus_addr;
  logic [3:0]    bus_be;
  logic [63:0]   bus_wdata, bus_rdata;
  logic          rsp_valid, flt_valid;
  logic [63:0]   rsp_data;
  logic [AW-1:0] flt_addr;
  logic [1:0]    flt_done;

  acc_split u_acc_split (.*);

  int errs = 0, checks = 0;
  logic stall_en = 1'b0, tog = 1'b0, bad_en = 1'b0;
  logic [19:0] bad_page = '0;

  always @(posedge clk) tog <= ~tog;
  assign bus_ready = stall_en ? tog : 1'b1;
  assign pg_ok = !(bad_en && bus_addr[31:12] == bad_page);

  function automatic logic [7:0] mem_b(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[3:0]} ^ 8'hA5;
  endfunction

  always_comb begin
    bus_rdata = '0;
    for (int j = 0; j < 8; j++)
      if (j < 4 || bus_wide) bus_rdata[8*j +: 8] = mem_b(bus_addr + 32'(j));
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // one request, checked end to end
  task automatic run(input logic [31:0] a, input logic [1:0] sz, input bit fp,
                     input bit nc, input bit st, input int exp_np,
                     input bit exp_flt, input logic [31:0] exp_fa);
    int nb, k, cyc, last_hs, nbytes_seen;
    bit done, got_rsp, got_flt, wide, hold;
    logic [31:0] prev_a, hold_a;
    logic [3:0] hold_be;
    logic [63:0] wd, exp_d;
    nb = 1 << sz;
    wide = fp && sz == 2'd3 && a[2:0] == 3'b000;
    wd = 64'h1122_3344_5566_7788 ^ {32'h0, a};
    exp_d = '0;
    for (int b = 0; b < nb; b++) exp_d[8*(nb-1-b) +: 8] = mem_b(a + 32'(b));
    k = 0; cyc = 0; last_hs = -9; nbytes_seen = 0; done = 0;
    got_rsp = 0; got_flt = 0; hold = 0; prev_a = '0; hold_a = '0; hold_be = '0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_size = sz; req_store = st;
    req_fpdbl = fp; req_nocache = nc; req_wdata = wd;
    while (!done && cyc < 60) begin
      #1;
      if (cyc == 0) chk(bus_valid && req_ready, "R2", "first piece with request", 64'(bus_valid), 1);
      if (cyc == 1 && !rsp_valid && !flt_valid) chk(!req_ready, "R1", "busy while outstanding", 64'(req_ready), 0);
      if (hold) begin
        chk(bus_valid && bus_addr == hold_a && bus_be == hold_be, "R10", "stalled piece held",
            64'(bus_addr), 64'(hold_a));
        hold = 0;
      end
      if (rsp_valid) begin got_rsp = 1; done = 1; end
      if (flt_valid) begin
        got_flt = 1; done = 1;
        chk(req_ready, "R9", "ready at fault", 64'(req_ready), 1);
      end
      if (!done && bus_valid && bus_ready) begin
        chk(bus_wide == wide, "R4", "wide flag", 64'(bus_wide), 64'(wide));
        chk(bus_store == st, "R3", "piece direction", 64'(bus_store), 64'(st));
        if (wide) chk(bus_be == 4'hF && bus_addr == a, "R4", "wide piece addr", 64'(bus_addr), 64'(a));
        else chk(bus_addr[1:0] == 0 && (k == 0 || bus_addr > prev_a), "R3", "piece addr order",
                 64'(bus_addr), 64'(prev_a));
        chk(bus_tnew == (k == 0 || (nc && !wide && !bus_addr[2])), "R5", "tenure marker",
            64'(bus_tnew), 64'(k == 0 || (nc && !wide && !bus_addr[2])));
        for (int j = 0; j < 8; j++) begin
          if (wide || (j < 4 && bus_be[j])) begin
            int b;
            b = int'(bus_addr + 32'(j) - a);
            chk(b >= 0 && b < nb, "R3", "enabled byte inside operand", 64'(b), 64'(nb));
            if (st && b >= 0 && b < nb)
              chk(bus_wdata[8*j +: 8] == wd[8*(nb-1-b) +: 8], "R6", "store lane",
                  64'(bus_wdata[8*j +: 8]), 64'(wd[8*(nb-1-b) +: 8]));
            nbytes_seen++;
          end
        end
        prev_a = bus_addr; last_hs = cyc; k++;
      end else if (!done && bus_valid && !bus_ready) begin
        hold = 1; hold_a = bus_addr; hold_be = bus_be;
      end
      @(negedge clk);
      req_valid = 0;
      cyc++;
    end
    if (!done) chk(0, "R1", "request never ended", 0, 1);
    chk(k == exp_np, "R3", "piece count", 64'(k), 64'(exp_np));
    if (exp_flt) begin
      chk(got_flt && !got_rsp, "R8", "fault raised", 64'(got_flt), 1);
      chk(flt_addr == exp_fa, "R8", "fault address", 64'(flt_addr), 64'(exp_fa));
      chk(flt_done == 2'(exp_np), "R9", "pieces done before fault", 64'(flt_done), 64'(exp_np));
    end else begin
      chk(got_rsp && !got_flt, "R7", "response raised", 64'(got_rsp), 1);
      chk(cyc - 1 - last_hs == 1 || (got_rsp && cyc - 1 - last_hs == 1), "R7", "response one cycle after last piece",
          64'(cyc - 1 - last_hs), 1);
      chk(nbytes_seen == nb, "R11", "bytes covered", 64'(nbytes_seen), 64'(nb));
      if (!st) chk(rsp_data == exp_d, "R7", "load data", rsp_data, exp_d);
    end
  endtask

  // {addr, size, fp, nc, store, pieces}
  localparam int NV = 13;
  localparam logic [38:0] VEC [NV] = '{
    {32'h100, 2'd2, 1'b0, 1'b0, 1'b0, 2'd1},
    {32'h103, 2'd0, 1'b0, 1'b0, 1'b1, 2'd1},
    {32'h102, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1},
    {32'h103, 2'd1, 1'b0, 1'b0, 1'b1, 2'd2},
    {32'h101, 2'd2, 1'b0, 1'b0, 1'b0, 2'd2},
    {32'h108, 2'd3, 1'b1, 1'b0, 1'b0, 2'd1},
    {32'h108, 2'd3, 1'b0, 1'b0, 1'b1, 2'd2},
    {32'h10A, 2'd3, 1'b1, 1'b0, 1'b0, 2'd3},
    {32'h106, 2'd2, 1'b0, 1'b1, 1'b1, 2'd2},
    {32'h104, 2'd3, 1'b1, 1'b1, 1'b0, 2'd2},
    {32'h206, 2'd2, 1'b0, 1'b0, 1'b0, 2'd2},
    {32'h110, 2'd3, 1'b1, 1'b1, 1'b1, 2'd1},
    {32'h10D, 2'd3, 1'b0, 1'b1, 1'b0, 2'd3}
  };

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_addr = '0; req_size = '0; req_store = 0;
    req_fpdbl = 0; req_nocache = 0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(req_ready && !bus_valid && !rsp_valid && !flt_valid, "R1", "reset idle",
        {60'd0, req_ready, bus_valid, rsp_valid, flt_valid}, 64'h8);

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      run(v[38:7], v[6:5], v[4], v[3], v[2], int'(v[1:0]), 1'b0, '0);
    end

    // R10 stalls on split and wide requests
    stall_en = 1;
    run(32'h101, 2'd2, 1'b0, 1'b0, 1'b0, 2, 1'b0, '0);
    run(32'h10A, 2'd3, 1'b1, 1'b0, 1'b1, 3, 1'b0, '0);
    run(32'h108, 2'd3, 1'b1, 1'b1, 1'b0, 1, 1'b0, '0);
    stall_en = 0;

    // R8 page crossing onto an allowed page
    run(32'h1FFE, 2'd2, 1'b0, 1'b0, 1'b0, 2, 1'b0, '0);
    // R8 / R9 refused page: load then store
    bad_en = 1; bad_page = 20'h1;
    run(32'hFFE, 2'd3, 1'b0, 1'b0, 1'b0, 1, 1'b1, 32'h1000);
    run(32'hFFF, 2'd2, 1'b0, 1'b1, 1'b1, 1, 1'b1, 32'h1000);
    // R9 next request accepted straight after a fault
    run(32'h0F0, 2'd2, 1'b0, 1'b0, 1'b0, 1, 1'b0, '0);
    // refused page on the first piece is not a crossing: normal completion
    run(32'h1004, 2'd1, 1'b0, 1'b0, 1'b0, 1, 1'b0, '0);
    bad_en = 0;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule